// File: doc/BRIEF.md
# Byte/Serial Control Word Loader

This block gathers a 40-bit configuration word for a frequency synthesis core and presents it, all at once, in the reference clock domain. The word is a 32-bit tuning word plus an 8-bit control byte. The control byte carries a 5-bit phase offset, a power-down flag and a 2-bit format field. Writers feed the word on a word-load clock, either as five bytes on an 8-bit port or as forty single bits on the top data bit.

A rising edge on the asynchronous update strobe commits the assembled input register into the working register. It also returns the byte pointer to the first byte. The strobe is turned into a toggle. The toggle passes through a two-flop synchronizer and an edge detector in the reference domain, and that edge performs the transfer. The same toggle is seen in the word-load domain, where it restarts the pointer and applies any change of loading format.

A master reset clears the working register, the pointer, the loading mode and the synchronizer. It leaves the input register untouched, so a later update commits whatever was last loaded.

Top module: `ctrl_word_loader`

## Requirements
- R1: In parallel mode the first byte written after an update is the control byte. The next four bytes are the tuning word, most significant byte first. Each byte is taken on a rising edge of `wr_clk`.
- R2: The control byte is decoded as follows: bits 7:3 are the phase offset (`phase_off`), bit 2 is power-down (`pwr_down`) and bits 1:0 are the format field.
- R3: The outputs do not change while bytes or bits are being written. They change only in the cycle in which `upd_pulse` is high.
- R4: After a rising edge of `upd`, the working register takes the input register on the third rising edge of `ref_clk`. In that same cycle `upd_pulse` goes high for exactly one cycle.
- R5: An update returns the byte pointer to the first byte. Bytes not rewritten after it keep their earlier values.
- R6: A sixth parallel write before an update is ignored, because the pointer saturates at five.
- R7: A committed format field of 2'b11 switches the loader to serial mode from the next write onward, and `serial_mode` reads 1. In serial mode, `data_in[7]` is shifted in least significant bit first, tuning word bit 0 first and control bit 7 last.
- R8: A committed format field other than 2'b11 returns the loader to parallel mode.
- R9: Master reset clears `tune_word`, `phase_off`, `pwr_down` and `serial_mode`, and restores parallel mode. It keeps the input register, so an update after reset commits the last loaded word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| rst | input | 1 | Master reset, active high, asynchronous |
| wr_clk | input | 1 | Word-load clock |
| data_in | input | 8 | Byte input; bit 7 is also the serial input |
| upd | input | 1 | Asynchronous update strobe, rising edge active |
| tune_word | output | 32 | Committed tuning word |
| phase_off | output | 5 | Committed phase offset |
| pwr_down | output | 1 | Committed power-down flag |
| serial_mode | output | 1 | High when the committed format selects serial loading |
| upd_pulse | output | 1 | One-cycle pulse marking a commit |

## Verification
A commit is due on the third `ref_clk` rising edge after the strobe rises. The monitor samples on falling edges, so it sees `upd_pulse` high in exactly one sample and compares all outputs in that sample against the oldest queued expected word. After each strobe the driver waits six reference cycles and then requires the queue to be empty, which catches a late or missing commit. Stability between updates is checked by comparing the outputs against the last commit after the writes, before the strobe.

// File: rtl/ctrl_word_loader.sv
module ctrl_word_loader #(
  parameter int TUNE_W = 32,
  parameter int CTRL_W = 8
) (
  input  logic              ref_clk,
  input  logic              rst,
  input  logic              wr_clk,
  input  logic [7:0]        data_in,
  input  logic              upd,
  output logic [TUNE_W-1:0] tune_word,
  output logic [4:0]        phase_off,
  output logic              pwr_down,
  output logic              serial_mode,
  output logic              upd_pulse
);
  localparam int WORD_W = TUNE_W + CTRL_W;
  localparam int NBYTES = WORD_W / 8;
  localparam int PTR_W  = $clog2(NBYTES + 1);

  logic [WORD_W-1:0] in_q, work_q;
  logic [PTR_W-1:0]  ptr, ptr_eff;
  logic              upd_tgl, seen, mode_q, new_upd, ser_eff;
  logic              s1, s2, s3;

  always_ff @(posedge upd or posedge rst)
    if (rst) upd_tgl <= 1'b0;
    else     upd_tgl <= ~upd_tgl;

  assign new_upd = upd_tgl ^ seen;
  assign ser_eff = new_upd ? (in_q[TUNE_W +: 2] == 2'b11) : mode_q;
  assign ptr_eff = new_upd ? '0 : ptr;

  always_ff @(posedge wr_clk)
    if (ser_eff)
      in_q <= {data_in[7], in_q[WORD_W-1:1]};
    else if (int'(ptr_eff) < NBYTES)
      in_q[(NBYTES - 1 - int'(ptr_eff)) * 8 +: 8] <= data_in;

  always_ff @(posedge wr_clk or posedge rst)
    if (rst) begin
      ptr    <= '0;
      seen   <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      seen   <= upd_tgl;
      mode_q <= ser_eff;
      if (!ser_eff && int'(ptr_eff) < NBYTES) ptr <= ptr_eff + PTR_W'(1);
      else                                    ptr <= ptr_eff;
    end

  always_ff @(posedge ref_clk or posedge rst)
    if (rst) begin
      {s1, s2, s3} <= '0;
      work_q       <= '0;
      upd_pulse    <= 1'b0;
    end else begin
      s1        <= upd_tgl;
      s2        <= s1;
      s3        <= s2;
      upd_pulse <= s2 ^ s3;
      if (s2 ^ s3) work_q <= in_q;
    end

  assign tune_word   = work_q[TUNE_W-1:0];
  assign phase_off   = work_q[TUNE_W+3 +: 5];
  assign pwr_down    = work_q[TUNE_W+2];
  assign serial_mode = (work_q[TUNE_W +: 2] == 2'b11);

  AST_PTR_SAT: assert property (@(posedge wr_clk) disable iff (rst) int'(ptr) <= NBYTES); // R6
  AST_PTR_RESTART: assert property (@(posedge wr_clk) disable iff (rst)
    (new_upd && !ser_eff) |=> ptr == PTR_W'(1)); // R5
  AST_PULSE_SINGLE: assert property (@(posedge ref_clk) disable iff (rst)
    upd_pulse |=> !upd_pulse); // R4
  AST_WORK_HOLD: assert property (@(posedge ref_clk) disable iff (rst)
    !upd_pulse |-> $stable(work_q)); // R3
  AST_MODE_HOLD: assert property (@(posedge ref_clk) disable iff (rst)
    !upd_pulse |-> $stable(serial_mode)); // R7
endmodule

// File: tb/test_ctrl_word_loader.sv
module test_ctrl_word_loader;
  logic        ref_clk = 1'b0, rst = 1'b1, wr_clk = 1'b0, upd = 1'b0;
  logic [7:0]  data_in = '0;
  logic [31:0] tune_word;
  logic [4:0]  phase_off;
  logic        pwr_down, serial_mode, upd_pulse;
  int          n_cmp = 0, n_bad = 0;
  logic [39:0] exp_q[$];
  logic [39:0] last = '0;
  logic [39:0] shadow = '0;

  always #4 ref_clk = ~ref_clk;

  ctrl_word_loader i_ctrl_word_loader (
    .ref_clk(ref_clk), .rst(rst), .wr_clk(wr_clk), .data_in(data_in), .upd(upd),
    .tune_word(tune_word), .phase_off(phase_off), .pwr_down(pwr_down),
    .serial_mode(serial_mode), .upd_pulse(upd_pulse));

  task automatic check(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [39:0] outs();
    return {phase_off, pwr_down, serial_mode ? 2'b11 : 2'b00, tune_word};
  endfunction

  function automatic logic [39:0] norm(input logic [39:0] w);
    return {w[39:34], (w[33:32] == 2'b11) ? 2'b11 : 2'b00, w[31:0]};
  endfunction

  always @(negedge ref_clk)
    if (!rst && upd_pulse) begin
      if (exp_q.size() == 0) check(1'b0, "R4 unexpected commit", outs(), '0);
      else begin
        logic [39:0] e;
        e = exp_q.pop_front();
        check(outs() == norm(e), "R1 R2 R7 commit contents", outs(), norm(e));
        last = e;
      end
    end

  task automatic wr(input logic [7:0] b);
    data_in = b; #3 wr_clk = 1'b1; #5 wr_clk = 1'b0; #3;
  endtask

  task automatic par(input logic [7:0] c, input logic [31:0] t);
    wr(c); wr(t[31:24]); wr(t[23:16]); wr(t[15:8]); wr(t[7:0]);
    shadow = {c, t};
  endtask

  task automatic ser(input logic [7:0] c, input logic [31:0] t);
    logic [39:0] w;
    w = {c, t};
    for (int i = 0; i < 40; i++) wr({w[i], 7'b0});
    shadow = w;
  endtask

  task automatic update(input logic [39:0] e, input string tag);
    check(outs() == norm(last), "R3 outputs held before update", outs(), norm(last));
    exp_q.push_back(e);
    #10 upd = 1'b1; #10 upd = 1'b0; #10;
    repeat (6) @(negedge ref_clk);
    check(exp_q.size() == 0, tag, 40'(exp_q.size()), 40'd0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge ref_clk);
    check(outs() == 40'd0, "R9 reset clears outputs", outs(), 40'd0);
    check(upd_pulse == 1'b0, "R9 no pulse in reset", 40'(upd_pulse), 40'd0);
    rst = 1'b0;
    last = '0;
    @(negedge ref_clk);
  endtask

  initial begin
    #500us;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    par(8'hA8, 32'h1234_5678);
    update(40'hA8_1234_5678, "R1 R4 parallel commit due");
    wr(8'h04); wr(8'h11); wr(8'h22);
    update(40'h04_1122_5678, "R5 partial reload commit");
    wr(8'h50); wr(8'h99);
    update(40'h50_9922_5678, "R5 pointer restarted at byte 0");
    par(8'h1C, 32'hDEAD_BEEF); wr(8'h77);
    update(40'h1C_DEAD_BEEF, "R6 sixth write ignored");
    par(8'h03, 32'h0000_0001);
    update(40'h03_0000_0001, "R7 serial format committed");
    check(serial_mode == 1'b1, "R7 serial_mode high", 40'(serial_mode), 40'd1);
    ser(8'hFB, 32'hCAFE_F00D);
    update(40'hFB_CAFE_F00D, "R7 serial lsb first load");
    ser(8'h60, 32'h0F0F_1234);
    update(40'h60_0F0F_1234, "R8 serial load back to parallel");
    check(serial_mode == 1'b0, "R8 serial_mode low", 40'(serial_mode), 40'd0);
    par(8'h88, 32'h0102_0304);
    update(40'h88_0102_0304, "R8 parallel loading restored");
    do_reset();
    check(serial_mode == 1'b0, "R9 mode parallel after reset", 40'(serial_mode), 40'd0);
    update(shadow, "R9 input register kept through reset");
    par(8'h03, 32'hAAAA_5555);
    update(40'h03_AAAA_5555, "R7 serial again");
    do_reset();
    par(8'h20, 32'h7654_3210);
    update(40'h20_7654_3210, "R9 reset restores parallel mode");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule